// File: doc/BRIEF.md
# Single-Bit Read-Modify-Write Access Unit

This unit sits between a command source and a 256-location byte-wide memory space and carries out operations on one bit at a time. A command names a bit through an 8-bit bit number and an operation: force the bit to one, force it to zero, flip it, write a supplied value into it, or only report it. The unit turns the bit number into a byte location and a bit position, fetches the byte through a read port, and, for the operations that change the bit, returns the byte through a write port with only that bit altered.

Bit numbers form their own numbering, separate from byte locations. The lower half of the bit numbers covers a 16-byte window of ordinary storage starting at byte 20H. The upper half covers only the bytes in the top region whose location is a multiple of 8. The commands arrive over a valid/ready handshake. The source holds `cmd_valid` and the command fields steady until a cycle in which `cmd_ready` is high. A transfer happens on a rising edge where both are high. While an operation is under way `cmd_ready` stays low, so a command offered during that time is not taken and has no effect. The result side is plain: a one-cycle `done` pulse and a held `test_bit`.

Top module: `bitacc_unit`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no operation is under way. A command offered while `cmd_ready` is low is not accepted and changes no memory byte or output.
- R2: A bit number b below 80H selects byte 20H + b[6:3], bit position b[2:0].
- R3: A bit number b of 80H or above selects byte {b[7:3], 000}, bit position b[2:0].
- R4: The `cmd_op` encoding is: 0 sets the bit, 1 clears it, 2 inverts it, 3 tests it, 4 writes `cmd_value` into it. The codes 5 to 7 behave as a test.
- R5: The read port is driven (`rd_en` high, `rd_addr` = the selected byte) for exactly one cycle, the cycle right after acceptance. `rd_data` is expected one cycle after `rd_en`.
- R6: For codes 0, 1, 2 and 4, `wr_en` is high for one cycle right after the read cycle. `wr_addr` is the byte that was read, and `wr_data` equals the read byte with only the selected bit replaced by its new value.
- R7: For codes 3, 5, 6 and 7, `wr_en` stays low for the whole operation.
- R8: `done` pulses for one cycle, three cycles after the acceptance edge. `cmd_ready` is high again in that same cycle.
- R9: On each `done` pulse, `test_bit` shows the selected bit's value as read, before any change. It holds that value until the next `done`.
- R10: After reset `cmd_ready` is 1, and `done`, `rd_en`, `wr_en` and `test_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, can take a command |
| cmd_op | input | 3 | Operation code (R4) |
| cmd_bitaddr | input | 8 | Bit number |
| cmd_value | input | 1 | Value for the write-bit operation |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 8 | Memory read byte location |
| rd_data | input | 8 | Read byte, valid one cycle after `rd_en` |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 8 | Memory write byte location |
| wr_data | output | 8 | Byte to write |
| done | output | 1 | Operation finished, one-cycle pulse |
| test_bit | output | 1 | Pre-operation value of the selected bit |

## Verification
Take the acceptance edge as edge 0. The read request is due in the cycle after edge 0. The write strobe, when there is one, is due in the cycle after edge 1. `done`, the new `test_bit` and the return of `cmd_ready` are due in the cycle after edge 2. The bench holds a reference model that is written behaviourally and advances on the same edges. It samples every output at the falling edge and compares each one against the model's expectation for that cycle. Through this cycle-exact comparison, a command offered while the unit is busy shows up as a mismatch at once if it is wrongly taken. A final sweep of all memory bytes confirms that no stray write occurred.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;
  typedef enum logic [2:0] {
    OP_SET  = 3'd0,
    OP_CLR  = 3'd1,
    OP_INV  = 3'd2,
    OP_TEST = 3'd3,
    OP_PUT  = 3'd4
  } bit_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_DATA = 2'd2
  } acc_state_e;

  // Codes that alter the selected bit; all others only report it.
  function automatic logic op_writes(input logic [2:0] op);
    return (op == OP_SET) || (op == OP_CLR) || (op == OP_INV) || (op == OP_PUT);
  endfunction
endpackage

// File: rtl/bitacc_map.sv
module bitacc_map #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PW = $clog2(DW),
  parameter logic [AW-1:0] WIN_BASE = 8'h20
) (
  input  logic [AW-1:0] bit_addr,
  output logic [AW-1:0] byte_addr,
  output logic [PW-1:0] bit_pos
);
  localparam int TOP = AW - 1;

  logic upper;
  assign upper   = bit_addr[TOP];
  assign bit_pos = bit_addr[PW-1:0];

  // R2: lower half indexes a window; R3: upper half hits multiples of DW.
  always_comb begin
    if (upper) byte_addr = {bit_addr[TOP:PW], {PW{1'b0}}};
    else       byte_addr = WIN_BASE + AW'(bit_addr[TOP-1:PW]);
  end
endmodule

// File: rtl/bitacc_modify.sv
module bitacc_modify
  import bitacc_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = $clog2(DW)
) (
  input  logic [DW-1:0] old_byte,
  input  logic [PW-1:0] pos,
  input  logic [2:0]    op,
  input  logic          put_val,
  output logic [DW-1:0] new_byte,
  output logic          old_bit
);
  logic nb;

  assign old_bit = old_byte[pos];

  always_comb begin
    case (op)
      OP_SET:  nb = 1'b1;
      OP_CLR:  nb = 1'b0;
      OP_INV:  nb = ~old_bit;
      OP_PUT:  nb = put_val;
      default: nb = old_bit;
    endcase
  end

  for (genvar i = 0; i < DW; i++) begin : g_lane
    assign new_byte[i] = (pos == PW'(i)) ? nb : old_byte[i];
  end
endmodule

// File: rtl/bitacc_unit.sv
module bitacc_unit
  import bitacc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] WIN_BASE = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_bitaddr,
  input  logic          cmd_value,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic          test_bit
);
  localparam int PW = $clog2(DW);

  acc_state_e    state;
  logic [2:0]    op_q;
  logic          val_q;
  logic [AW-1:0] byte_q;
  logic [PW-1:0] pos_q;
  logic          done_q;
  logic          bit_q;

  logic [AW-1:0] map_byte;
  logic [PW-1:0] map_pos;
  logic [DW-1:0] mod_byte;
  logic          mod_old;
  logic          accept;

  bitacc_map #(.AW(AW), .DW(DW), .PW(PW), .WIN_BASE(WIN_BASE)) u_map (
    .bit_addr (cmd_bitaddr),
    .byte_addr(map_byte),
    .bit_pos  (map_pos)
  );

  bitacc_modify #(.DW(DW), .PW(PW)) u_mod (
    .old_byte(rd_data),
    .pos     (pos_q),
    .op      (op_q),
    .put_val (val_q),
    .new_byte(mod_byte),
    .old_bit (mod_old)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= OP_TEST;
      val_q  <= 1'b0;
      byte_q <= '0;
      pos_q  <= '0;
      done_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          op_q   <= cmd_op;
          val_q  <= cmd_value;
          byte_q <= map_byte;
          pos_q  <= map_pos;
          state  <= ST_READ;
        end
        ST_READ: state <= ST_DATA;
        ST_DATA: begin
          done_q <= 1'b1;
          bit_q  <= mod_old;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_en    = (state == ST_READ);
  assign rd_addr  = byte_q;
  assign wr_en    = (state == ST_DATA) && op_writes(op_q);
  assign wr_addr  = byte_q;
  assign wr_data  = mod_byte;
  assign done     = done_q;
  assign test_bit = bit_q;

  assert_accept_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rd_en);
  assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  assert_write_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en) && (wr_addr == $past(rd_addr)));
  assert_one_bit_changed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $countones(wr_data ^ rd_data) <= 1);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  assert_busy_no_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !cmd_ready);
  assert_bit_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(test_bit));
endmodule

// File: tb/bitacc_unit_bench.sv
module bitacc_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_bitaddr = 8'd0;
  logic       cmd_value = 1'b0;
  logic       rd_en;
  logic [7:0] rd_addr;
  logic [7:0] rd_data = 8'd0;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       done;
  logic       test_bit;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bitacc_unit u_bitacc_unit (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bitaddr(cmd_bitaddr), .cmd_value(cmd_value),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .test_bit(test_bit)
  );

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'((i * 37 + 5) ^ (i >> 2));
      ref_mem[i] = 8'((i * 37 + 5) ^ (i >> 2));
    end
  end

  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // Behavioural reference model.
  int         ph = 0;
  int         m_op = 0;
  int         m_val = 0;
  int         m_addr = 0;
  int         m_byte = 0;
  int         m_pos = 0;
  int         exp_done = 0;
  int         exp_bit = 0;

  function automatic int ref_byte(input int a);
    if (a < 128) return 32 + (a / 8);
    return a - (a % 8);
  endfunction

  function automatic bit ref_writes(input int op);
    return op == 0 || op == 1 || op == 2 || op == 4;
  endfunction

  function automatic int ref_new(input int op, input int old, input int v);
    case (op)
      0: return 1;
      1: return 0;
      2: return 1 - old;
      4: return v;
      default: return old;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; exp_done = 0; exp_bit = 0;
    end else begin
      exp_done = 0;
      case (ph)
        0: if (cmd_valid) begin
          m_op = cmd_op; m_val = cmd_value; m_addr = cmd_bitaddr;
          m_byte = ref_byte(m_addr); m_pos = m_addr % 8; ph = 1;
        end
        1: ph = 2;
        default: begin
          exp_bit = ref_mem[m_byte][m_pos];
          if (ref_writes(m_op))
            ref_mem[m_byte][m_pos] = 1'(ref_new(m_op, exp_bit, m_val));
          exp_done = 1;
          ph = 0;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 cmd_ready", int'(cmd_ready), int'(ph == 0));
      chk("R5 rd_en", int'(rd_en), int'(ph == 1));
      if (ph == 1) begin
        if (m_addr < 128) chk("R2 rd_addr low window", int'(rd_addr), m_byte);
        else              chk("R3 rd_addr upper region", int'(rd_addr), m_byte);
      end
      if (ph == 2 && ref_writes(m_op)) begin
        logic [7:0] e;
        e = ref_mem[m_byte];
        e[m_pos] = 1'(ref_new(m_op, int'(e[m_pos]), m_val));
        chk("R6 wr_en", int'(wr_en), 1);
        chk("R6 wr_addr", int'(wr_addr), m_byte);
        chk("R4 wr_data", int'(wr_data), int'(e));
      end else begin
        chk("R7 wr_en low", int'(wr_en), 0);
      end
      chk("R8 done", int'(done), exp_done);
      chk("R9 test_bit", int'(test_bit), exp_bit);
    end
  end

  task automatic send(input int op, input int a, input int v);
    @(negedge clk); #2;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_bitaddr = 8'(a); cmd_value = 1'(v);
    @(negedge clk); #2;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 cmd_ready", int'(cmd_ready), 1);
    chk("R10 done", int'(done), 0);
    chk("R10 rd_en", int'(rd_en), 0);
    chk("R10 wr_en", int'(wr_en), 0);
    chk("R10 test_bit", int'(test_bit), 0);
    #2 rst_n = 1'b1;
    // Directed corners of both regions, every code.
    send(0, 8'h00, 0);
    send(1, 8'h7F, 0);
    send(2, 8'h80, 0);
    send(3, 8'hE7, 0);
    send(4, 8'h35, 1);
    send(4, 8'h35, 0);
    send(2, 8'hF8, 0);
    send(5, 8'h12, 1);
    send(7, 8'hD0, 1);
    send(3, 8'h00, 0);
    // Streamed stimulus; offers during busy cycles must be ignored (R1).
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #2;
      lfsr = step(lfsr);
      cmd_valid = lfsr[0] | lfsr[1];
      cmd_op    = lfsr[4:2];
      cmd_value = lfsr[5];
      lfsr = step(lfsr);
      cmd_bitaddr = lfsr[7:0];
    end
    @(negedge clk); #2 cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 256; i++)
      chk("R6 R7 final memory byte", int'(mem[i]), int'(ref_mem[i]));
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule